// File: doc/BRIEF.md
# Match-Compare Watchdog Timer

This block is a watchdog timer with a small word-addressed register port. A free-running up-counter advances once per clock while enabled. It is compared for equality against a programmable match value. When the two become equal, the block can act in several ways, each chosen by a control field:

- latch an interrupt flag;
- zero the counter and stop it;
- set, clear or toggle an external match pin;
- start a reset pulse of programmable length on an internal reset line, or on both the internal and external reset lines.

Software can also hold either reset line high directly, without waiting for a match.

In normal use, software first clears the counter and polls it until it reads zero. It then programs the match value, the pulse length and the match actions, and enables counting. It must keep restarting the counter before the match value is reached. A debug-halt input can freeze the counter while a debugger holds the core. A sticky status bit remembers that the block drove a system reset. Only the power-on reset input clears that bit, so software can tell, after the system restarts, that the watchdog caused it.

Top module: `match_wdog`

## Requirements
- R1: After reset, all registers read zero: interrupt flag, control, counter, match control, match value, external match, pulse length, and status once power-on reset was also applied. `irq_o`, `match_o`, `sys_rst_o` and `ext_rst_o` are low.
- R2: Word index 1 (byte address 0x04) is the control register. While its bit 0 is set, the counter at word index 2 (0x08) rises by one per clock. Writing 0 to control stops it, and it then holds its value.
- R3: While control bit 1 is set, the counter is forced to zero on every clock and reads back as zero.
- R4: While control bit 2 is set and `dbg_halt_i` is high, the counter holds its value. With bit 2 clear, `dbg_halt_i` has no effect.
- R5: A match event is the counter equalling the match value (word index 4, 0x10) while control bit 0 is set. On a match event with match-control (word index 3, 0x0C) bit 0 set, interrupt flag bit 0 (word index 0) and `irq_o` go high one clock after the equality. No event occurs while control bit 0 is clear, even when the values are equal.
- R6: Writing 1 to interrupt flag bit 0 clears it. Writing 0 leaves it unchanged.
- R7: On a match event with match-control bit 2 set, the next clock sees the counter at zero and control bit 0 cleared.
- R8: On a match event, match-control bit 3 starts a pulse on `sys_rst_o`, and bit 4 starts a pulse on both `sys_rst_o` and `ext_rst_o`. The pulse starts one clock after the equality and lasts L+1 clocks, where L is the 16-bit pulse length at word index 6 (0x18).
- R9: Match-control bit 5 holds `sys_rst_o` high. Bit 6 holds both `sys_rst_o` and `ext_rst_o` high. Both act immediately, without a match.
- R10: External-match register (word index 5, 0x14) bit 0 is the `match_o` level and is writable. On a match event, bits [5:4] act on it: 0 holds it, 1 drives it low, 2 drives it high, 3 toggles it.
- R11: Status bit 0 (word index 7, 0x1C) is set once `sys_rst_o` has been high. Writes to it are ignored. `rst_n` leaves it unchanged, and only `por_n` clears it.
- R12: A match event fires once, even when the equality persists for many clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| por_n | input | 1 | Asynchronous active-low power-on reset; also clears the status flag |
| dbg_halt_i | input | 1 | Debugger holds the core; pauses the counter when enabled |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | AW (5) | Byte address; bits [4:2] select the word |
| bus_wdata_i | input | DW (32) | Write data |
| bus_rdata_o | output | DW (32) | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Match interrupt flag |
| match_o | output | 1 | External match pin level |
| sys_rst_o | output | 1 | Internal (system) reset request |
| ext_rst_o | output | 1 | External reset request |

## Verification
The bench builds the block with its default widths: a 32-bit counter and match register, a 16-bit pulse length and a 5-bit address. It programs match values of a few counts and pulse lengths of 0 and 3, so every match event and every pulse edge falls within a few clocks of the enabling write and can be sampled in a known cycle. A match value of 0 combined with the counter-clear bit keeps the equality true for many clocks, which exposes any repeat firing. Separate `rst_n` and `por_n` pulses show which state each reset reaches.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Word indices inside the register window (byte address >> 2).
  localparam logic [2:0] IDX_IRQ   = 3'd0;
  localparam logic [2:0] IDX_CTRL  = 3'd1;
  localparam logic [2:0] IDX_CNT   = 3'd2;
  localparam logic [2:0] IDX_MCTRL = 3'd3;
  localparam logic [2:0] IDX_MATCH = 3'd4;
  localparam logic [2:0] IDX_EMR   = 3'd5;
  localparam logic [2:0] IDX_PLS   = 3'd6;
  localparam logic [2:0] IDX_STAT  = 3'd7;

  // Control bits.
  localparam int CB_RUN = 0;
  localparam int CB_CLR = 1;
  localparam int CB_DBG = 2;

  // Match-control bits.
  localparam int MB_IRQ  = 0;
  localparam int MB_STOP = 2;
  localparam int MB_RST1 = 3;
  localparam int MB_RST2 = 4;
  localparam int MB_FRC1 = 5;
  localparam int MB_FRC2 = 6;

  // Action on the match pin when a match event occurs.
  typedef enum logic [1:0] {
    EM_HOLD = 2'd0,
    EM_LOW  = 2'd1,
    EM_HIGH = 2'd2,
    EM_FLIP = 2'd3
  } emr_act_e;

endpackage

// File: rtl/wdog_rsync.sv
// Reset synchronizer: asserts asynchronously, releases on the second clock edge.
module wdog_rsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= 2'b00;
    else         sh_q <= {sh_q[0], 1'b1};
  end

  assign srst_n = sh_q[1];
endmodule

// File: rtl/wdog_counter.sv
// Up-counter with clear, debug pause, and equality match with single-fire edge detect.
module wdog_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             dbg_en_i,
  input  logic             dbg_halt_i,
  input  logic             stop_on_hit_i,
  input  logic [CNT_W-1:0] match_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             evt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             hit, hit_q;

  assign hit   = run_i & (cnt_q == match_i);
  assign evt_o = hit & ~hit_q;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clr_i || (evt_o && stop_on_hit_i)) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (run_i && !(dbg_en_i && dbg_halt_i)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      hit_q <= hit;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdog_pulse.sv
// One reset pulse channel: high for len+1 clocks after fire, retriggerable.
module wdog_pulse #(
  parameter int PLS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic [PLS_W-1:0] len_i,
  output logic             active_o
);
  localparam logic [PLS_W-1:0] ONE = PLS_W'(1);

  logic             act_q, act_d;
  logic [PLS_W-1:0] rem_q, rem_d;

  always_comb begin
    act_d = act_q;
    rem_d = rem_q;
    if (fire_i) begin
      act_d = 1'b1;
      rem_d = len_i;
    end else if (act_q) begin
      if (rem_q == '0) act_d = 1'b0;
      else             rem_d = rem_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      rem_q <= '0;
    end else begin
      act_q <= act_d;
      rem_q <= rem_d;
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/wdog_extmatch.sv
// Match pin level: software write, overridden by the selected action on a match event.
module wdog_extmatch
  import wdog_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_i,
  input  logic     wr_lvl_i,
  input  logic     evt_i,
  input  emr_act_e act_i,
  output logic     lvl_o
);
  logic lvl_q, lvl_d;

  always_comb begin
    lvl_d = lvl_q;
    if (evt_i) begin
      case (act_i)
        EM_LOW:  lvl_d = 1'b0;
        EM_HIGH: lvl_d = 1'b1;
        EM_FLIP: lvl_d = ~lvl_q;
        default: lvl_d = lvl_q;
      endcase
    end else if (wr_i) begin
      lvl_d = wr_lvl_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/match_wdog.sv
module match_wdog
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PLS_W = 16,
  parameter int DW    = 32,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          por_n,
  input  logic          dbg_halt_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          irq_o,
  output logic          match_o,
  output logic          sys_rst_o,
  output logic          ext_rst_o
);
  localparam int IW     = 3;
  localparam int NWORD  = 1 << IW;
  localparam int NCHAN  = 2;
  localparam int CTRL_W = 3;
  localparam int MCTL_W = 7;

  // Resets: block state follows both inputs, the status flag only power-on.
  logic blk_rst_n, por_rst_n;
  wdog_rsync u_rs_blk (.clk(clk), .arst_n(rst_n & por_n), .srst_n(blk_rst_n));
  wdog_rsync u_rs_por (.clk(clk), .arst_n(por_n),         .srst_n(por_rst_n));

  // Address decode.
  logic [IW-1:0]    widx;
  logic             in_map;
  logic [NWORD-1:0] wsel;
  logic             unused_addr_lsb;

  assign widx            = bus_addr_i[IW+1:2];
  assign unused_addr_lsb = ^bus_addr_i[1:0];

  generate
    if (AW > IW + 2) begin : g_hi_dec
      assign in_map = (bus_addr_i[AW-1:IW+2] == '0);
    end else begin : g_no_hi
      assign in_map = 1'b1;
    end
  endgenerate

  always_comb begin
    wsel = '0;
    if (bus_we_i && in_map) wsel[widx] = 1'b1;
  end

  // Registers.
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [MCTL_W-1:0] mctrl_q, mctrl_d;
  logic [CNT_W-1:0]  match_q, match_d;
  emr_act_e          emact_q, emact_d;
  logic [PLS_W-1:0]  plen_q, plen_d;
  logic              irqf_q, irqf_d;
  logic              wdflag_q, wdflag_d;

  logic [CNT_W-1:0]  cnt;
  logic              evt;
  logic              lvl;
  logic [NCHAN-1:0]  fire, pact;

  always_comb begin
    ctrl_d   = ctrl_q;
    mctrl_d  = mctrl_q;
    match_d  = match_q;
    emact_d  = emact_q;
    plen_d   = plen_q;
    irqf_d   = irqf_q;
    wdflag_d = wdflag_q | sys_rst_o;

    if (wsel[IDX_CTRL])  ctrl_d  = bus_wdata_i[CTRL_W-1:0];
    if (wsel[IDX_MCTRL]) mctrl_d = bus_wdata_i[MCTL_W-1:0];
    if (wsel[IDX_MATCH]) match_d = bus_wdata_i[CNT_W-1:0];
    if (wsel[IDX_EMR])   emact_d = emr_act_e'(bus_wdata_i[5:4]);
    if (wsel[IDX_PLS])   plen_d  = bus_wdata_i[PLS_W-1:0];

    // Event wins over a same-cycle write.
    if (evt && mctrl_q[MB_STOP]) ctrl_d[CB_RUN] = 1'b0;
    if (wsel[IDX_IRQ] && bus_wdata_i[0]) irqf_d = 1'b0;
    if (evt && mctrl_q[MB_IRQ])          irqf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge blk_rst_n) begin
    if (!blk_rst_n) begin
      ctrl_q  <= '0;
      mctrl_q <= '0;
      match_q <= '0;
      emact_q <= EM_HOLD;
      plen_q  <= '0;
      irqf_q  <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      mctrl_q <= mctrl_d;
      match_q <= match_d;
      emact_q <= emact_d;
      plen_q  <= plen_d;
      irqf_q  <= irqf_d;
    end
  end

  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n) wdflag_q <= 1'b0;
    else            wdflag_q <= wdflag_d;
  end

  // Counter and compare.
  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk           (clk),
    .rst_n         (blk_rst_n),
    .run_i         (ctrl_q[CB_RUN]),
    .clr_i         (ctrl_q[CB_CLR]),
    .dbg_en_i      (ctrl_q[CB_DBG]),
    .dbg_halt_i    (dbg_halt_i),
    .stop_on_hit_i (mctrl_q[MB_STOP]),
    .match_i       (match_q),
    .cnt_o         (cnt),
    .evt_o         (evt)
  );

  // Match pin.
  wdog_extmatch u_em (
    .clk      (clk),
    .rst_n    (blk_rst_n),
    .wr_i     (wsel[IDX_EMR]),
    .wr_lvl_i (bus_wdata_i[0]),
    .evt_i    (evt),
    .act_i    (emact_q),
    .lvl_o    (lvl)
  );

  // Reset pulse channels: 0 = internal only, 1 = internal and external.
  assign fire[0] = evt & mctrl_q[MB_RST1];
  assign fire[1] = evt & mctrl_q[MB_RST2];

  generate
    for (genvar g = 0; g < NCHAN; g++) begin : g_pulse
      wdog_pulse #(.PLS_W(PLS_W)) u_pulse (
        .clk      (clk),
        .rst_n    (blk_rst_n),
        .fire_i   (fire[g]),
        .len_i    (plen_q),
        .active_o (pact[g])
      );
    end
  endgenerate

  assign sys_rst_o = pact[0] | pact[1] | mctrl_q[MB_FRC1] | mctrl_q[MB_FRC2];
  assign ext_rst_o = pact[1] | mctrl_q[MB_FRC2];
  assign irq_o     = irqf_q;
  assign match_o   = lvl;

  // Read mux.
  always_comb begin
    bus_rdata_o = '0;
    if (in_map) begin
      case (widx)
        IDX_IRQ:   bus_rdata_o[0]          = irqf_q;
        IDX_CTRL:  bus_rdata_o[CTRL_W-1:0] = ctrl_q;
        IDX_CNT:   bus_rdata_o[CNT_W-1:0]  = cnt;
        IDX_MCTRL: bus_rdata_o[MCTL_W-1:0] = mctrl_q;
        IDX_MATCH: bus_rdata_o[CNT_W-1:0]  = match_q;
        IDX_EMR: begin
          bus_rdata_o[5:4] = emact_q;
          bus_rdata_o[0]   = lvl;
        end
        IDX_PLS:   bus_rdata_o[PLS_W-1:0]  = plen_q;
        default:   bus_rdata_o[0]          = wdflag_q;
      endcase
    end
  end
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             por_n,
  input logic             dbg_halt,
  input logic [2:0]       ctrl,
  input logic [6:0]       mctrl,
  input logic [CNT_W-1:0] cnt,
  input logic             evt,
  input logic             irqf,
  input logic             sys_rst,
  input logic             ext_rst,
  input logic             wdflag
);
  a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !ctrl[1]) |=> $stable(cnt));

  a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[1] |=> (cnt == '0));

  a_r4_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && ctrl[2] && dbg_halt && !ctrl[1] && !(evt && mctrl[2])) |=> $stable(cnt));

  a_r5_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqf) |-> $past(evt && mctrl[0]));

  a_r7_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && mctrl[2]) |=> (cnt == '0 && !ctrl[0]));

  a_r8_ext_has_sys: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst |-> sys_rst);

  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    sys_rst |=> wdflag);

  a_r12_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
endmodule

bind match_wdog wdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (blk_rst_n),
  .por_n    (por_rst_n),
  .dbg_halt (dbg_halt_i),
  .ctrl     (ctrl_q),
  .mctrl    (mctrl_q),
  .cnt      (cnt),
  .evt      (evt),
  .irqf     (irqf_q),
  .sys_rst  (sys_rst_o),
  .ext_rst  (ext_rst_o),
  .wdflag   (wdflag_q)
);

// File: tb/match_wdog_tb.sv
module match_wdog_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 5;

  localparam logic [2:0] W_IRQ = 3'd0, W_CTRL = 3'd1, W_CNT = 3'd2, W_MCTRL = 3'd3,
                         W_MATCH = 3'd4, W_EMR = 3'd5, W_PLS = 3'd6, W_STAT = 3'd7;

  logic          clk = 1'b0;
  logic          rst_n, por_n, dbg_halt_i, bus_we_i;
  logic [AW-1:0] bus_addr_i;
  logic [DW-1:0] bus_wdata_i, bus_rdata_o;
  logic          irq_o, match_o, sys_rst_o, ext_rst_o;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  match_wdog u_dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .dbg_halt_i(dbg_halt_i),
    .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .irq_o(irq_o), .match_o(match_o),
    .sys_rst_o(sys_rst_o), .ext_rst_o(ext_rst_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    bus_addr_i  = {idx, 2'b00};
    bus_wdata_i = d;
    bus_we_i    = 1'b1;
    @(negedge clk);
    bus_we_i    = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    bus_addr_i = {idx, 2'b00};
    #1;
    d = bus_rdata_o;
  endtask

  task automatic zero_cnt();
    wr(W_CTRL, 32'd2);
    wr(W_CTRL, 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq_o", irq_o, 0);
    chk("R1 match_o", match_o, 0);
    chk("R1 sys_rst_o", sys_rst_o, 0);
    chk("R1 ext_rst_o", ext_rst_o, 0);
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), d);
      chk($sformatf("R1 word %0d", i), d, 0);
    end
  endtask

  task automatic t_count();
    logic [31:0] d;
    zero_cnt();
    wr(W_CTRL, 32'd1);
    repeat (5) @(negedge clk);
    rd(W_CNT, d); chk("R2 count after 5", d, 5);
    wr(W_CTRL, 32'd0);
    repeat (3) @(negedge clk);
    rd(W_CNT, d); chk("R2 held after stop", d, 6);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(W_CTRL, 32'd3);
    @(negedge clk);
    rd(W_CNT, d); chk("R3 cleared", d, 0);
    repeat (3) @(negedge clk);
    rd(W_CNT, d); chk("R3 held at zero", d, 0);
    wr(W_CTRL, 32'd0);
  endtask

  task automatic t_debug();
    logic [31:0] d;
    dbg_halt_i = 1'b1;
    wr(W_CTRL, 32'd5);
    repeat (4) @(negedge clk);
    rd(W_CNT, d); chk("R4 paused by halt", d, 0);
    dbg_halt_i = 1'b0;
    repeat (3) @(negedge clk);
    rd(W_CNT, d); chk("R4 runs after halt", d, 3);
    dbg_halt_i = 1'b1;
    repeat (2) @(negedge clk);
    rd(W_CNT, d); chk("R4 paused again", d, 3);
    wr(W_CTRL, 32'd1);
    repeat (2) @(negedge clk);
    rd(W_CNT, d); chk("R4 halt ignored when bit2 clear", d, 5);
    wr(W_CTRL, 32'd0);
    dbg_halt_i = 1'b0;
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(W_MATCH, 32'd10);
    wr(W_MCTRL, 32'd1);
    zero_cnt();
    wr(W_CTRL, 32'd1);
    repeat (10) @(negedge clk);
    rd(W_CNT, d); chk("R5 counter at match", d, 10);
    chk("R5 irq not yet", irq_o, 0);
    @(negedge clk);
    chk("R5 irq after match", irq_o, 1);
    rd(W_IRQ, d); chk("R5 irq flag bit", d, 1);
    chk("R5 no reset pulse", sys_rst_o, 0);
    repeat (3) @(negedge clk);
    wr(W_CTRL, 32'd0);
    wr(W_IRQ, 32'd0);
    chk("R6 write 0 keeps flag", irq_o, 1);
    wr(W_IRQ, 32'd1);
    chk("R6 write 1 clears flag", irq_o, 0);
    rd(W_CNT, d);
    wr(W_MATCH, d);
    repeat (4) @(negedge clk);
    chk("R5 no event while stopped", irq_o, 0);
  endtask

  task automatic t_stop();
    logic [31:0] d;
    wr(W_MCTRL, 32'd5);
    wr(W_MATCH, 32'd4);
    zero_cnt();
    wr(W_CTRL, 32'd1);
    repeat (4) @(negedge clk);
    rd(W_CNT, d); chk("R7 reaches match", d, 4);
    @(negedge clk);
    rd(W_CNT, d); chk("R7 counter zeroed", d, 0);
    rd(W_CTRL, d); chk("R7 run bit cleared", d, 0);
    chk("R7 irq set", irq_o, 1);
    repeat (3) @(negedge clk);
    rd(W_CNT, d); chk("R7 stays stopped", d, 0);
    wr(W_IRQ, 32'd1);
    wr(W_MCTRL, 32'd0);
  endtask

  task automatic t_pulse();
    logic [31:0] d;
    wr(W_PLS, 32'd3);
    wr(W_MCTRL, 32'd8);
    wr(W_MATCH, 32'd2);
    zero_cnt();
    rd(W_STAT, d); chk("R11 flag clear before pulse", d, 0);
    wr(W_CTRL, 32'd1);
    repeat (2) @(negedge clk);
    chk("R8 no pulse before match", sys_rst_o, 0);
    @(negedge clk);
    chk("R8 sys pulse starts", sys_rst_o, 1);
    chk("R8 ext stays low", ext_rst_o, 0);
    repeat (3) @(negedge clk);
    chk("R8 sys pulse last clock", sys_rst_o, 1);
    @(negedge clk);
    chk("R8 sys pulse ended", sys_rst_o, 0);
    rd(W_STAT, d); chk("R11 flag set by pulse", d, 1);
    wr(W_CTRL, 32'd0);
    wr(W_PLS, 32'd0);
    wr(W_MCTRL, 32'd16);
    wr(W_MATCH, 32'd1);
    zero_cnt();
    wr(W_CTRL, 32'd1);
    @(negedge clk);
    @(negedge clk);
    chk("R8 both pulse sys", sys_rst_o, 1);
    chk("R8 both pulse ext", ext_rst_o, 1);
    @(negedge clk);
    chk("R8 length 0 gives one clock", {sys_rst_o, ext_rst_o}, 0);
    wr(W_CTRL, 32'd0);
    wr(W_MCTRL, 32'd0);
  endtask

  task automatic t_force();
    wr(W_MCTRL, 32'd32);
    chk("R9 force1 sys", sys_rst_o, 1);
    chk("R9 force1 ext", ext_rst_o, 0);
    wr(W_MCTRL, 32'd64);
    chk("R9 force2 both", {sys_rst_o, ext_rst_o}, 2'b11);
    wr(W_MCTRL, 32'd0);
    chk("R9 release", {sys_rst_o, ext_rst_o}, 0);
  endtask

  task automatic run_to_match(input logic [31:0] m);
    wr(W_MATCH, m);
    zero_cnt();
    wr(W_CTRL, 32'd1);
    repeat (m + 1) @(negedge clk);
    wr(W_CTRL, 32'd0);
  endtask

  task automatic t_ext();
    logic [31:0] d;
    wr(W_EMR, 32'h01);
    chk("R10 write level", match_o, 1);
    wr(W_EMR, 32'h11);
    run_to_match(2);
    chk("R10 action 1 drives low", match_o, 0);
    wr(W_EMR, 32'h20);
    rd(W_EMR, d); chk("R10 readback", d, 32'h20);
    run_to_match(2);
    chk("R10 action 2 drives high", match_o, 1);
    wr(W_EMR, 32'h00);
    wr(W_EMR, 32'h01);
    run_to_match(3);
    chk("R10 action 0 holds", match_o, 1);
  endtask

  task automatic t_once();
    wr(W_EMR, 32'h30);
    wr(W_MATCH, 32'd0);
    zero_cnt();
    wr(W_CTRL, 32'd3);
    chk("R12 before event", match_o, 0);
    @(negedge clk);
    chk("R12 toggled once", match_o, 1);
    repeat (5) @(negedge clk);
    chk("R12 no second toggle", match_o, 1);
    wr(W_CTRL, 32'd0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    rd(W_STAT, d); chk("R11 flag still set", d, 1);
    wr(W_STAT, 32'd0);
    rd(W_STAT, d); chk("R11 write ignored", d, 1);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(W_STAT, d); chk("R11 survives block reset", d, 1);
    rd(W_EMR, d); chk("R1 block reset clears regs", d, 0);
    por_n = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(W_STAT, d); chk("R11 cleared by power-on", d, 0);
  endtask

  initial begin
    rst_n = 1'b0; por_n = 1'b0; dbg_halt_i = 1'b0;
    bus_we_i = 1'b0; bus_addr_i = '0; bus_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_count();
    t_clear();
    t_debug();
    t_irq();
    t_stop();
    t_pulse();
    t_force();
    t_ext();
    t_once();
    t_status();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule